// File: doc/BRIEF.md
# Loop Detection and Profitability Tracker

This block sits beside the decoder and watches each decoded instruction. When a taken backward branch appears, it learns the loop that the branch closes. It adds up the backend resources the loop body needs, and it stores the loop's bounds and the unroll factor that fits the backend in a small direct-mapped table. Later, when the decoder reaches the first instruction of a stored loop that is still worth running in place, the block switches into dispatch mode. It emits a one-cycle start strobe together with the stored unroll factor and the address that follows the loop.

Each table entry carries a 4-bit saturating profitability score. A newly learned loop starts at 8, and in-place dispatch is allowed only while the score is 8 or more. Feedback from the execution core raises the score when an unrolled body ran more than twice and lowers it otherwise. A mispredict that leaves the loop for any address other than the fall-through wipes the score to zero. A disabled loop slowly earns its way back through dispatch successes that the frontend observes.

Top module: `loop_detect_top`

## Requirements
- R1: After reset, `mode` is idle (encoding 0) and `disp_start` is low. `mode` only ever takes the values 0 (idle), 1 (train) and 2 (dispatch).
- R2: In idle, a decoded taken backward branch whose PC does not start a profitable stored loop moves `mode` to train on the next cycle.
- R3: In train, the instruction at the recorded branch PC is the loop end when it is again a taken backward branch to the recorded target. Every instruction decoded after the training branch is summed, up to and including that end instruction. If the sum is between 1 and CAP and no serializing instruction was seen, an entry is written with score 8 and unroll = min(floor(CAP/sum), 2^UW-1). The mode then returns to idle. A loop whose start is already stored keeps its existing entry and score.
- R4: Decoding the start PC of a stored loop with score ≥ 8 in idle or train raises `disp_start` for exactly one cycle, with `mode` = 2, the stored unroll on `disp_unroll` and end PC + 2^ALIGN on `disp_fallthru`.
- R5: Dispatch mode holds until `disp_done`, and then returns to idle on the next cycle.
- R6: A training run whose summed cost exceeds CAP, or that contains an instruction with `dec_serial` set, writes no entry and leaves the table unchanged.
- R7: In train, a taken backward branch that is not the recorded loop end restarts training. The new branch PC and target are recorded, the sum is cleared, and the restarting branch's own cost is not counted.
- R8: In train, decoding a profitable stored loop start abandons training and enters dispatch as in R4.
- R9: The table is direct-mapped, indexed by PC bits [ALIGN +: log2(DEPTH)], and confirmed by a full start-address compare. A new loop written to an occupied index replaces the old one.
- R10: `fb_kind` 1 adds 2 to the score of the loop whose start equals `fb_pc`, and `fb_kind` 2 subtracts 2. Dispatch is allowed only at a score of 8 or more.
- R11: The score saturates at 15 and at 0 and never wraps.
- R12: `fb_kind` 3 (mispredict off the fall-through path) forces the score to 0.
- R13: For a loop with a score below 8, every second `obs_valid` pulse naming its start adds 1 to the score. Any feedback event clears a half-counted pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_pc | input | AW | PC of the decoded instruction |
| dec_bwd_taken | input | 1 | Instruction is a taken PC-relative backward branch |
| dec_target | input | AW | Branch target |
| dec_cost | input | CW | Backend resources used by this instruction |
| dec_serial | input | 1 | Instruction is serializing |
| disp_done | input | 1 | Loop-mode execution has ended |
| fb_valid | input | 1 | Backend feedback event |
| fb_pc | input | AW | Start PC of the loop the feedback refers to |
| fb_kind | input | 2 | 1 long run, 2 short run, 3 off-path mispredict |
| obs_valid | input | 1 | Frontend observed a successful dispatch opportunity |
| obs_pc | input | AW | Start PC of the observed loop |
| mode | output | 2 | 0 idle, 1 train, 2 dispatch |
| disp_start | output | 1 | One-cycle loop-dispatch strobe |
| disp_unroll | output | UW | Unroll factor for the dispatch |
| disp_fallthru | output | AW | Address after the loop end |

## Verification
The bench builds the block with AW=16, CAP=16, DEPTH=4, ALIGN=2, UW=4 and CW=4. A capacity of 16 means a four-instruction body at cost 5 already overflows, while cheap bodies give unroll factors of 4 and 8 that stay below the 4-bit limit of 15. With four entries and word alignment, starts 0x100 and 0x140 share index 0, so eviction and the full tag compare are reachable. The score paths are walked to both rails and back across the threshold, with each step made visible through whether a decode of the loop start produces a dispatch strobe.

// File: rtl/loopdet_pkg.sv
package loopdet_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_TRAIN = 2'd1,
    MODE_DISP  = 2'd2
  } mode_e;

  localparam logic [1:0] FB_LONG    = 2'd1;
  localparam logic [1:0] FB_SHORT   = 2'd2;
  localparam logic [1:0] FB_OFFPATH = 2'd3;

  localparam logic [3:0] PROF_INIT = 4'd8;
  localparam logic [3:0] PROF_MAX  = 4'd15;

  function automatic logic [3:0] prof_up2(input logic [3:0] p);
    return (p > 4'd13) ? PROF_MAX : p + 4'd2;
  endfunction

  function automatic logic [3:0] prof_dn2(input logic [3:0] p);
    return (p < 4'd2) ? 4'd0 : p - 4'd2;
  endfunction
endpackage

// File: rtl/loop_table.sv
module loop_table
  import loopdet_pkg::*;
#(
  parameter int AW    = 32,
  parameter int UW    = 4,
  parameter int DEPTH = 4,
  parameter int ALIGN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] look_pc,
  output logic          look_hit,
  output logic          look_ok,
  output logic [UW-1:0] look_unroll,
  output logic [AW-1:0] look_end,
  input  logic          ins_en,
  input  logic [AW-1:0] ins_start,
  input  logic [AW-1:0] ins_end,
  input  logic [UW-1:0] ins_unroll,
  input  logic          fb_valid,
  input  logic [AW-1:0] fb_pc,
  input  logic [1:0]    fb_kind,
  input  logic          obs_valid,
  input  logic [AW-1:0] obs_pc
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] st_a [DEPTH];
  logic [AW-1:0] en_a [DEPTH];
  logic [UW-1:0] un_a [DEPTH];
  logic [3:0]    pr_a [DEPTH];
  logic          vl_a [DEPTH];

  logic [IW-1:0] look_idx, ins_idx;
  logic          ins_dup;

  assign look_idx = look_pc[ALIGN +: IW];
  assign ins_idx  = ins_start[ALIGN +: IW];

  always_comb begin
    look_hit    = vl_a[look_idx] && (st_a[look_idx] == look_pc);
    look_ok     = pr_a[look_idx] >= PROF_INIT;
    look_unroll = un_a[look_idx];
    look_end    = en_a[look_idx];
    ins_dup     = vl_a[ins_idx] && (st_a[ins_idx] == ins_start);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [AW-1:0] st_q, en_q;
    logic [UW-1:0] un_q;
    logic [3:0]    pr_q;
    logic          vl_q, half_q;
    logic          ins_h, fb_h, obs_h;

    assign ins_h = ins_en && !ins_dup && (ins_idx == IW'(g));
    assign fb_h  = fb_valid && vl_q && (st_q == fb_pc);
    assign obs_h = obs_valid && vl_q && (st_q == obs_pc) && (pr_q < PROF_INIT);

    always_ff @(posedge clk) begin
      if (rst) begin
        vl_q   <= 1'b0;
        st_q   <= '0;
        en_q   <= '0;
        un_q   <= '0;
        pr_q   <= '0;
        half_q <= 1'b0;
      end else if (ins_h) begin
        vl_q   <= 1'b1;
        st_q   <= ins_start;
        en_q   <= ins_end;
        un_q   <= ins_unroll;
        pr_q   <= PROF_INIT;
        half_q <= 1'b0;
      end else if (fb_h) begin
        half_q <= 1'b0;
        case (fb_kind)
          FB_LONG:    pr_q <= prof_up2(pr_q);
          FB_SHORT:   pr_q <= prof_dn2(pr_q);
          FB_OFFPATH: pr_q <= 4'd0;
          default:    pr_q <= pr_q;
        endcase
      end else if (obs_h) begin
        if (half_q) begin
          pr_q   <= pr_q + 4'd1;
          half_q <= 1'b0;
        end else begin
          half_q <= 1'b1;
        end
      end
    end

    assign st_a[g] = st_q;
    assign en_a[g] = en_q;
    assign un_a[g] = un_q;
    assign pr_a[g] = pr_q;
    assign vl_a[g] = vl_q;
  end
endmodule

// File: rtl/train_accum.sv
module train_accum #(
  parameter int CW  = 4,
  parameter int CAP = 64,
  parameter int UW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          add,
  input  logic [CW-1:0] cost,
  input  logic          ser,
  output logic          fin_ok,
  output logic [UW-1:0] fin_unroll
);
  localparam int SW = $clog2(CAP + 1) + 1;
  localparam int XW = SW + CW + UW;
  localparam logic [XW-1:0] CAPX = XW'(CAP);
  localparam logic [XW-1:0] UMAX = XW'((1 << UW) - 1);

  logic [SW-1:0] sum_q;
  logic          ser_q;
  logic [XW-1:0] tot, quo;
  logic          over;

  always_comb begin
    tot    = XW'(sum_q) + XW'(cost);
    over   = tot > CAPX;
    quo    = (tot == '0) ? '0 : CAPX / tot;
    fin_ok = !over && (tot != '0) && !ser_q && !ser;
    fin_unroll = (quo > UMAX) ? UMAX[UW-1:0] : quo[UW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum_q <= '0;
      ser_q <= 1'b0;
    end else if (add) begin
      sum_q <= over ? SW'(CAP + 1) : tot[SW-1:0];
      ser_q <= ser_q | ser;
    end
  end
endmodule

// File: rtl/loop_fsm.sv
module loop_fsm
  import loopdet_pkg::*;
#(
  parameter int AW    = 32,
  parameter int UW    = 4,
  parameter int ALIGN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic [AW-1:0] dec_pc,
  input  logic          dec_bwd,
  input  logic [AW-1:0] dec_tgt,
  input  logic          disp_done,
  input  logic          look_hit,
  input  logic          look_ok,
  input  logic [UW-1:0] look_unroll,
  input  logic [AW-1:0] look_end,
  input  logic          fin_ok,
  input  logic [UW-1:0] fin_unroll,
  output logic          acc_clr,
  output logic          acc_add,
  output logic          ins_en,
  output logic [AW-1:0] ins_start,
  output logic [AW-1:0] ins_end,
  output logic [UW-1:0] ins_unroll,
  output logic [1:0]    mode_o,
  output logic          start_o,
  output logic [UW-1:0] unroll_o,
  output logic [AW-1:0] ft_o
);
  localparam logic [AW-1:0] STEP = AW'(1 << ALIGN);

  mode_e         st_q, st_d;
  logic [AW-1:0] tr_start_q, tr_end_q;
  logic          go, is_end, restart, begin_tr;

  always_comb begin
    go       = dec_valid && look_hit && look_ok && (st_q != MODE_DISP);
    is_end   = (st_q == MODE_TRAIN) && dec_valid && dec_bwd &&
               (dec_pc == tr_end_q) && (dec_tgt == tr_start_q);
    restart  = (st_q == MODE_TRAIN) && dec_valid && dec_bwd && !is_end;
    begin_tr = (st_q == MODE_IDLE) && dec_valid && dec_bwd;
    acc_clr  = (begin_tr || restart) && !go;
    acc_add  = (st_q == MODE_TRAIN) && dec_valid && !go && !restart;
    ins_en   = is_end && !go && fin_ok;
    ins_start  = tr_start_q;
    ins_end    = tr_end_q;
    ins_unroll = fin_unroll;

    st_d = st_q;
    if (go) st_d = MODE_DISP;
    else begin
      case (st_q)
        MODE_IDLE:  if (begin_tr) st_d = MODE_TRAIN;
        MODE_TRAIN: if (is_end) st_d = MODE_IDLE;
        MODE_DISP:  if (disp_done) st_d = MODE_IDLE;
        default:    st_d = MODE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= MODE_IDLE;
      tr_start_q <= '0;
      tr_end_q   <= '0;
      start_o    <= 1'b0;
      unroll_o   <= '0;
      ft_o       <= '0;
    end else begin
      st_q    <= st_d;
      start_o <= go;
      if (acc_clr) begin
        tr_start_q <= dec_tgt;
        tr_end_q   <= dec_pc;
      end
      if (go) begin
        unroll_o <= look_unroll;
        ft_o     <= look_end + STEP;
      end
    end
  end

  assign mode_o = st_q;
endmodule

// File: rtl/loop_detect_top.sv
module loop_detect_top #(
  parameter int AW    = 32,
  parameter int CW    = 4,
  parameter int CAP   = 64,
  parameter int DEPTH = 4,
  parameter int UW    = 4,
  parameter int ALIGN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic [AW-1:0] dec_pc,
  input  logic          dec_bwd_taken,
  input  logic [AW-1:0] dec_target,
  input  logic [CW-1:0] dec_cost,
  input  logic          dec_serial,
  input  logic          disp_done,
  input  logic          fb_valid,
  input  logic [AW-1:0] fb_pc,
  input  logic [1:0]    fb_kind,
  input  logic          obs_valid,
  input  logic [AW-1:0] obs_pc,
  output logic [1:0]    mode,
  output logic          disp_start,
  output logic [UW-1:0] disp_unroll,
  output logic [AW-1:0] disp_fallthru
);
  logic          look_hit, look_ok;
  logic [UW-1:0] look_unroll, fin_unroll, ins_unroll;
  logic [AW-1:0] look_end, ins_start, ins_end;
  logic          fin_ok, acc_clr, acc_add, ins_en;

  loop_table #(.AW(AW), .UW(UW), .DEPTH(DEPTH), .ALIGN(ALIGN)) u_tab (
    .clk(clk), .rst(rst),
    .look_pc(dec_pc), .look_hit(look_hit), .look_ok(look_ok),
    .look_unroll(look_unroll), .look_end(look_end),
    .ins_en(ins_en), .ins_start(ins_start), .ins_end(ins_end), .ins_unroll(ins_unroll),
    .fb_valid(fb_valid), .fb_pc(fb_pc), .fb_kind(fb_kind),
    .obs_valid(obs_valid), .obs_pc(obs_pc)
  );

  train_accum #(.CW(CW), .CAP(CAP), .UW(UW)) u_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .add(acc_add),
    .cost(dec_cost), .ser(dec_serial),
    .fin_ok(fin_ok), .fin_unroll(fin_unroll)
  );

  loop_fsm #(.AW(AW), .UW(UW), .ALIGN(ALIGN)) u_fsm (
    .clk(clk), .rst(rst),
    .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_bwd(dec_bwd_taken), .dec_tgt(dec_target),
    .disp_done(disp_done),
    .look_hit(look_hit), .look_ok(look_ok), .look_unroll(look_unroll), .look_end(look_end),
    .fin_ok(fin_ok), .fin_unroll(fin_unroll),
    .acc_clr(acc_clr), .acc_add(acc_add),
    .ins_en(ins_en), .ins_start(ins_start), .ins_end(ins_end), .ins_unroll(ins_unroll),
    .mode_o(mode), .start_o(disp_start), .unroll_o(disp_unroll), .ft_o(disp_fallthru)
  );
endmodule

// File: rtl/loopdet_chk.sv
module loopdet_chk #(
  parameter int UW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          dec_valid,
  input logic          dec_bwd_taken,
  input logic          disp_done,
  input logic [1:0]    mode,
  input logic          disp_start,
  input logic [UW-1:0] disp_unroll
);
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd3); // R1

  AST_TRAIN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(mode == 2'd1) |-> $past(dec_valid && dec_bwd_taken)); // R2

  AST_UNROLL_NONZERO: assert property (@(posedge clk) disable iff (rst)
    disp_start |-> disp_unroll != '0); // R3

  AST_START_IN_DISPATCH: assert property (@(posedge clk) disable iff (rst)
    disp_start |-> mode == 2'd2); // R4

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    disp_start |=> !disp_start); // R4

  AST_DISPATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && !disp_done) |=> mode == 2'd2); // R5

  AST_DISPATCH_EXIT: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && disp_done) |=> mode == 2'd0); // R5
endmodule

bind loop_detect_top loopdet_chk #(.UW(UW)) u_chk (
  .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_bwd_taken(dec_bwd_taken),
  .disp_done(disp_done), .mode(mode), .disp_start(disp_start), .disp_unroll(disp_unroll)
);

// File: tb/sim_loop_detect_top.sv
module sim_loop_detect_top;
  localparam int AW = 16, CW = 4, CAP = 16, DEPTH = 4, UW = 4, ALIGN = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic dec_valid = 0, dec_bwd_taken = 0, dec_serial = 0, disp_done = 0;
  logic fb_valid = 0, obs_valid = 0;
  logic [AW-1:0] dec_pc = '0, dec_target = '0, fb_pc = '0, obs_pc = '0;
  logic [CW-1:0] dec_cost = '0;
  logic [1:0] fb_kind = '0;
  logic [1:0] mode;
  logic disp_start;
  logic [UW-1:0] disp_unroll;
  logic [AW-1:0] disp_fallthru;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_detect_top #(.AW(AW), .CW(CW), .CAP(CAP), .DEPTH(DEPTH), .UW(UW), .ALIGN(ALIGN)) u0 (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_pc(dec_pc),
    .dec_bwd_taken(dec_bwd_taken), .dec_target(dec_target), .dec_cost(dec_cost),
    .dec_serial(dec_serial), .disp_done(disp_done), .fb_valid(fb_valid),
    .fb_pc(fb_pc), .fb_kind(fb_kind), .obs_valid(obs_valid), .obs_pc(obs_pc),
    .mode(mode), .disp_start(disp_start), .disp_unroll(disp_unroll),
    .disp_fallthru(disp_fallthru)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic issue(logic [AW-1:0] pc, logic bwd, logic [AW-1:0] tgt,
                       logic [CW-1:0] cost, logic ser);
    dec_valid = 1; dec_pc = pc; dec_bwd_taken = bwd; dec_target = tgt;
    dec_cost = cost; dec_serial = ser;
    step();
    dec_valid = 0; dec_bwd_taken = 0; dec_serial = 0;
  endtask

  task automatic train_loop(logic [AW-1:0] start, int n, logic [CW-1:0] cost, logic ser);
    logic [AW-1:0] endpc;
    endpc = start + AW'(4 * (n - 1));
    issue(endpc, 1, start, cost, 0);
    chk("R2", "mode after backward branch", 32'(mode), 1);
    for (int k = 0; k < n; k++)
      issue(start + AW'(4 * k), k == n - 1, start, cost, ser && (k == 1));
    chk("R3", "mode after loop end", 32'(mode), 0);
  endtask

  task automatic try_dispatch(string req, logic [AW-1:0] start, bit expect_go,
                              logic [UW-1:0] unr, logic [AW-1:0] ft);
    issue(start, 0, 0, 1, 0);
    chk(req, "disp_start", 32'(disp_start), 32'(expect_go));
    chk(req, "mode", 32'(mode), expect_go ? 2 : 0);
    if (expect_go) begin
      chk("R4", "disp_unroll", 32'(disp_unroll), 32'(unr));
      chk("R4", "disp_fallthru", 32'(disp_fallthru), 32'(ft));
      step();
      chk("R4", "strobe single cycle", 32'(disp_start), 0);
      chk("R5", "dispatch held", 32'(mode), 2);
      disp_done = 1; step(); disp_done = 0;
      chk("R5", "idle after done", 32'(mode), 0);
    end
  endtask

  task automatic fb(logic [AW-1:0] pc, logic [1:0] kind, int times);
    for (int k = 0; k < times; k++) begin
      fb_valid = 1; fb_pc = pc; fb_kind = kind; step(); fb_valid = 0;
    end
  endtask

  task automatic obs(logic [AW-1:0] pc, int times);
    for (int k = 0; k < times; k++) begin
      obs_valid = 1; obs_pc = pc; step(); obs_valid = 0;
    end
  endtask

  task automatic t_reset();
    chk("R1", "mode at reset", 32'(mode), 0);
    chk("R1", "strobe at reset", 32'(disp_start), 0);
  endtask

  task automatic t_basic();
    train_loop(16'h0100, 4, 1, 0);
    try_dispatch("R4", 16'h0100, 1, 4, 16'h0110);
  endtask

  task automatic t_reject();
    train_loop(16'h0200, 4, 5, 0);
    try_dispatch("R6", 16'h0200, 0, 0, 0);
    try_dispatch("R6", 16'h0100, 1, 4, 16'h0110);
    train_loop(16'h0204, 3, 1, 1);
    try_dispatch("R6", 16'h0204, 0, 0, 0);
  endtask

  task automatic t_restart();
    issue(16'h032C, 1, 16'h0300, 3, 0);
    issue(16'h0300, 0, 0, 3, 0);
    issue(16'h0304, 0, 0, 3, 0);
    issue(16'h0308, 1, 16'h0304, 3, 0);
    chk("R7", "still training", 32'(mode), 1);
    issue(16'h0304, 0, 0, 1, 0);
    issue(16'h0308, 1, 16'h0304, 1, 0);
    chk("R7", "idle after restarted end", 32'(mode), 0);
    try_dispatch("R7", 16'h0304, 1, 8, 16'h030C);
  endtask

  task automatic t_abort();
    issue(16'h041C, 1, 16'h0400, 1, 0);
    chk("R8", "training", 32'(mode), 1);
    try_dispatch("R8", 16'h0100, 1, 4, 16'h0110);
  endtask

  task automatic t_conflict();
    train_loop(16'h0140, 2, 1, 0);
    try_dispatch("R9", 16'h0100, 0, 0, 0);
    try_dispatch("R9", 16'h0140, 1, 8, 16'h0148);
  endtask

  task automatic t_feedback();
    fb(16'h0140, 2'd2, 1);
    try_dispatch("R10", 16'h0140, 0, 0, 0);
    train_loop(16'h0140, 2, 1, 0);
    try_dispatch("R3", 16'h0140, 0, 0, 0);
    fb(16'h0140, 2'd1, 1);
    try_dispatch("R10", 16'h0140, 1, 8, 16'h0148);
  endtask

  task automatic t_saturate();
    fb(16'h0140, 2'd1, 5);
    fb(16'h0140, 2'd2, 4);
    try_dispatch("R11", 16'h0140, 0, 0, 0);
    fb(16'h0140, 2'd2, 5);
    fb(16'h0140, 2'd1, 4);
    try_dispatch("R11", 16'h0140, 1, 8, 16'h0148);
  endtask

  task automatic t_mispredict();
    fb(16'h0140, 2'd3, 1);
    fb(16'h0140, 2'd1, 3);
    try_dispatch("R12", 16'h0140, 0, 0, 0);
    fb(16'h0140, 2'd1, 1);
    try_dispatch("R12", 16'h0140, 1, 8, 16'h0148);
  endtask

  task automatic t_recover();
    fb(16'h0140, 2'd2, 1);
    obs(16'h0140, 3);
    try_dispatch("R13", 16'h0140, 0, 0, 0);
    obs(16'h0140, 1);
    try_dispatch("R13", 16'h0140, 1, 8, 16'h0148);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    step(); step();
    rst = 0;
    step();
    t_reset();
    t_basic();
    t_reject();
    t_restart();
    t_abort();
    t_conflict();
    t_feedback();
    t_saturate();
    t_mispredict();
    t_recover();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule